// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage that sits between the OR sums of a programmable logic array and its I/O pins. Each cell takes one OR sum and one output-enable term. A two-bit mode field then chooses whether the cell drives the pin through a D flip-flop or straight from the sum, and whether the pin is active high or active low. Each cell also returns a feedback signal to the array. That feedback is the flip-flop state in registered modes and the pin level in combinatorial modes. A combinatorial cell whose output enable is held low therefore works as a plain input.

All cells share the clock, an array-generated asynchronous clear term, a synchronous preset term, and a test preload strobe. Preload writes each flip-flop from its own pin value, so test sequences can force any state directly, including states the logic could never reach. A security input blocks preload. The active-low power-up reset clears every flip-flop. The cell count is a parameter, and each cell has its own mode field, so all four modes can run side by side.

Top module: `out_macrocell_bank`

## Requirements
- R1: Mode field per cell is two bits: bit 1 selects the path (0 registered, 1 combinatorial) and bit 0 the polarity (1 active high, 0 active low). In registered modes the pin equals the flip-flop state when bit 0 is 1 and its inverse when bit 0 is 0.
- R2: With no clear, preload or preset active, each flip-flop takes its OR sum on the rising clock edge.
- R3: With the preset term high (and no clear or enabled preload), every flip-flop becomes 1 at the next rising edge; the pin then shows that 1 through the cell's polarity.
- R4: The clear term forces every flip-flop to 0 at once, without a clock edge, and wins over preset and preload while it is high.
- R5: While `rst_ni` is low, every flip-flop is 0.
- R6: In combinatorial modes the pin equals the OR sum (bit 0 = 1) or its inverse (bit 0 = 0) in the same cycle; the flip-flop keeps clocking but does not reach the pin.
- R7: Feedback equals the flip-flop state in registered modes and the pin input in combinatorial modes.
- R8: Each pin output enable equals that cell's enable term. A combinatorial cell with its enable low still returns its pin input as feedback.
- R9: With preload high and security low, every flip-flop takes its own pin input at the rising edge. Preload wins over preset and over the OR sum.
- R10: With security high, preload has no effect, and the flip-flops follow R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| clr_term_i | input | 1 | Shared asynchronous clear term, active high |
| set_term_i | input | 1 | Shared synchronous preset term, active high |
| preload_i | input | 1 | Test preload strobe |
| secure_i | input | 1 | Blocks preload when high |
| sum_i | input | N_CELLS | OR sum per cell |
| oe_term_i | input | N_CELLS | Output-enable term per cell |
| mode_i | input | N_CELLS x 2 | Mode field per cell (bit 1 path, bit 0 polarity) |
| pin_i | input | N_CELLS | Level seen on each pin |
| pin_o | output | N_CELLS | Value driven toward each pin |
| pin_oe_o | output | N_CELLS | Output buffer enable per pin |
| fb_o | output | N_CELLS | Feedback per cell to the array |

## Verification
The clocked properties assume that the clear term is held for whole clock cycles and does not pulse between two edges. They also assume that the sum, pin, preset and preload inputs settle before each edge. The stimulus changes every input only on the falling clock edge. It raises and drops the clear term at falling edges too, so its immediate effect can be observed half a cycle before the next rising edge. The mode fields stay fixed, with one cell in each of the four modes. Because of this, each property is exercised in every mode under the same shared control inputs.

// File: rtl/omc_pkg.sv
`timescale 1ns/1ps
package omc_pkg;
  localparam int MODE_W = 2;
  localparam int PATH_BIT = 1;
  localparam int POL_BIT  = 0;

  typedef enum logic [MODE_W-1:0] {
    MODE_REG_LOW   = 2'b00,
    MODE_REG_HIGH  = 2'b01,
    MODE_COMB_LOW  = 2'b10,
    MODE_COMB_HIGH = 2'b11
  } cell_mode_e;
endpackage

// File: rtl/omc_flop.sv
`timescale 1ns/1ps
module omc_flop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  input  logic preload_i,
  input  logic secure_i,
  input  logic d_i,
  input  logic pin_i,
  output logic q_o
);
  logic load_en;
  assign load_en = preload_i & ~secure_i;

  // priority: power-up, clear, preload, preset, data
  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (clr_i)   q_o <= 1'b0;
    else if (load_en) q_o <= pin_i;
    else if (set_i)   q_o <= 1'b1;
    else              q_o <= d_i;
  end

  AST_CLR_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !q_o) else $error("clear term did not hold flop low"); // R4
  AST_PRELOAD_FROM_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && preload_i && !secure_i) |=> (clr_i || q_o == $past(pin_i)))
    else $error("preload did not take pin value"); // R9
  AST_PRESET_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !preload_i && set_i) |=> (clr_i || q_o))
    else $error("preset did not set flop"); // R3
  AST_SECURE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && preload_i && secure_i && !set_i) |=> (clr_i || q_o == $past(d_i)))
    else $error("secured preload altered flop"); // R10
  AST_CAPTURE_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !preload_i && !set_i) |=> (clr_i || q_o == $past(d_i)))
    else $error("flop did not capture sum"); // R2
endmodule

// File: rtl/omc_outsel.sv
`timescale 1ns/1ps
module omc_outsel
  import omc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              q_i,
  input  logic              sum_i,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              fb_o
);
  cell_mode_e mode;
  logic       comb_path;
  logic       act_high;
  logic       core;

  assign mode = cell_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_REG_LOW:   begin comb_path = 1'b0; act_high = 1'b0; end
      MODE_REG_HIGH:  begin comb_path = 1'b0; act_high = 1'b1; end
      MODE_COMB_LOW:  begin comb_path = 1'b1; act_high = 1'b0; end
      default:        begin comb_path = 1'b1; act_high = 1'b1; end
    endcase
  end

  assign core  = comb_path ? sum_i : q_i;
  assign pin_o = act_high ? core : ~core;
  assign fb_o  = comb_path ? pin_i : q_i;

  AST_REG_HIGH_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_REG_HIGH) |-> (pin_o == q_i)) else $error("reg high pin"); // R1
  AST_REG_LOW_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_REG_LOW) |-> (pin_o != q_i)) else $error("reg low pin"); // R1
  AST_COMB_HIGH_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_COMB_HIGH) |-> (pin_o == sum_i)) else $error("comb high pin"); // R6
  AST_COMB_LOW_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_COMB_LOW) |-> (pin_o != sum_i)) else $error("comb low pin"); // R6
  AST_FB_FROM_Q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[PATH_BIT] |-> (fb_o == q_i)) else $error("reg feedback"); // R7
  AST_FB_FROM_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[PATH_BIT] |-> (fb_o == pin_i)) else $error("comb feedback"); // R7
endmodule

// File: rtl/omc_cell.sv
`timescale 1ns/1ps
module omc_cell
  import omc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              set_i,
  input  logic              preload_i,
  input  logic              secure_i,
  input  logic              sum_i,
  input  logic              oe_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              fb_o
);
  logic q;

  omc_flop u_flop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .set_i     (set_i),
    .preload_i (preload_i),
    .secure_i  (secure_i),
    .d_i       (sum_i),
    .pin_i     (pin_i),
    .q_o       (q)
  );

  omc_outsel u_outsel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .q_i    (q),
    .sum_i  (sum_i),
    .pin_i  (pin_i),
    .pin_o  (pin_o),
    .fb_o   (fb_o)
  );

  assign pin_oe_o = oe_i;

  AST_OE_FOLLOWS_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_i) |-> pin_oe_o) else $error("enable term not passed"); // R8
endmodule

// File: rtl/out_macrocell_bank.sv
`timescale 1ns/1ps
module out_macrocell_bank
  import omc_pkg::*;
#(
  parameter int N_CELLS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_term_i,
  input  logic                           set_term_i,
  input  logic                           preload_i,
  input  logic                           secure_i,
  input  logic [N_CELLS-1:0]             sum_i,
  input  logic [N_CELLS-1:0]             oe_term_i,
  input  logic [N_CELLS-1:0][MODE_W-1:0] mode_i,
  input  logic [N_CELLS-1:0]             pin_i,
  output logic [N_CELLS-1:0]             pin_o,
  output logic [N_CELLS-1:0]             pin_oe_o,
  output logic [N_CELLS-1:0]             fb_o
);
  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    omc_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_term_i),
      .set_i     (set_term_i),
      .preload_i (preload_i),
      .secure_i  (secure_i),
      .sum_i     (sum_i[k]),
      .oe_i      (oe_term_i[k]),
      .mode_i    (mode_i[k]),
      .pin_i     (pin_i[k]),
      .pin_o     (pin_o[k]),
      .pin_oe_o  (pin_oe_o[k]),
      .fb_o      (fb_o[k])
    );
  end
endmodule

// File: tb/tb_out_macrocell_bank.sv
`timescale 1ns/1ps
module tb_out_macrocell_bank;
  localparam int N = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              clr_term = 1'b0, set_term = 1'b0, preload = 1'b0, secure = 1'b0;
  logic [N-1:0]      sum = '0, oe = '0, pin_in = '0;
  logic [N-1:0][1:0] mode;
  logic [N-1:0]      pin_o, pin_oe_o, fb_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model_q = '0;

  typedef struct {
    logic [N-1:0] pin;
    logic [N-1:0] oe;
    logic [N-1:0] fb;
    string        tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  // cell k runs mode k: 00 reg low, 01 reg high, 10 comb low, 11 comb high
  assign mode = {2'b11, 2'b10, 2'b01, 2'b00};

  out_macrocell_bank #(.N_CELLS(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_term_i(clr_term), .set_term_i(set_term),
    .preload_i(preload), .secure_i(secure), .sum_i(sum), .oe_term_i(oe),
    .mode_i(mode), .pin_i(pin_in), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .fb_o(fb_o)
  );

  function automatic logic [N-1:0] exp_pin(input logic [N-1:0] q, input logic [N-1:0] s);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) begin
      logic v;
      v = mode[k][1] ? s[k] : q[k];
      r[k] = mode[k][0] ? v : ~v;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_fb(input logic [N-1:0] q, input logic [N-1:0] p);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = mode[k][1] ? p[k] : q[k];
    return r;
  endfunction

  task automatic check_vec(input string tag, input string what,
                           input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // driver: apply inputs at falling edge, push outputs expected after next rising edge
  task automatic step(input logic [N-1:0] s, input logic [N-1:0] e, input logic [N-1:0] p,
                      input logic sp, input logic pl, input logic sec, input logic ar,
                      input string tag);
    exp_t it;
    @(negedge clk);
    sum = s; oe = e; pin_in = p;
    set_term = sp; preload = pl; secure = sec; clr_term = ar;
    if (ar)             model_q = '0;
    else if (pl && !sec) model_q = p;
    else if (sp)        model_q = '1;
    else                model_q = s;
    it.pin = exp_pin(model_q, s);
    it.oe  = e;
    it.fb  = exp_fb(model_q, p);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        check_vec(it.tag, "pin_o", pin_o, it.pin);
        check_vec(it.tag, "pin_oe_o", pin_oe_o, it.oe);
        check_vec(it.tag, "fb_o", fb_o, it.fb);
      end
    end
  end

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R5 reset state: all flops 0
    sum = 4'b0000; pin_in = 4'b0000; oe = 4'b1111;
    repeat (3) @(posedge clk);
    #2;
    check_vec("R5", "pin_o", pin_o, exp_pin('0, sum));
    check_vec("R5", "fb_o", fb_o, exp_fb('0, pin_in));
    @(negedge clk);
    rst_ni = 1'b1;

    step(4'b1111, 4'b1111, 4'b0000, 0, 0, 0, 0, "R2 capture ones");
    step(4'b0000, 4'b1111, 4'b1010, 0, 0, 0, 0, "R2 capture zeros");
    step(4'b0101, 4'b0011, 4'b0000, 0, 0, 0, 0, "R1 R6 polarity");
    step(4'b0000, 4'b1111, 4'b0000, 1, 0, 0, 0, "R3 preset");
    step(4'b0000, 4'b1111, 4'b0110, 1, 1, 0, 0, "R9 preload over preset");
    step(4'b1111, 4'b1111, 4'b1001, 0, 1, 0, 0, "R9 preload from pin");
    step(4'b1010, 4'b1111, 4'b0101, 0, 1, 1, 0, "R10 secure blocks preload");
    step(4'b0000, 4'b1111, 4'b0101, 1, 1, 1, 0, "R10 secure then preset");

    // R4 immediate clear: flops are 1 here; raise clear mid-cycle and look before the edge
    @(negedge clk);
    clr_term = 1'b1;
    #1;
    model_q = '0;
    check_vec("R4 async", "fb_o", fb_o, exp_fb('0, pin_in));
    check_vec("R4 async", "pin_o", pin_o, exp_pin('0, sum));
    step(4'b1111, 4'b1111, 4'b1111, 1, 1, 0, 1, "R4 clear wins");
    step(4'b1111, 4'b1111, 4'b1111, 0, 0, 0, 0, "R2 after clear");

    // R8 enable low, comb cells act as inputs
    step(4'b0000, 4'b0000, 4'b1100, 0, 0, 0, 0, "R8 dedicated input");
    step(4'b0000, 4'b0000, 4'b0100, 0, 0, 0, 0, "R8 R7 pin feedback");

    for (int i = 0; i < 40; i++) begin
      logic sp, pl, sec;
      sp  = 1'($urandom());
      pl  = 1'($urandom());
      sec = 1'($urandom());
      step(4'($urandom()), 4'($urandom()), 4'($urandom()), sp, pl, sec, 0, "R2 R3 R7 R9 mix");
    end

    // R5 reset mid-run clears flops at once
    step(4'b1111, 4'b1111, 4'b0000, 0, 0, 0, 0, "R2 before reset");
    @(negedge clk);
    #1;
    rst_ni = 1'b0;
    #1;
    check_vec("R5 midrun", "fb_o", fb_o, exp_fb('0, pin_in));
    check_vec("R5 midrun", "pin_o", pin_o, exp_pin('0, sum));

    repeat (3) @(posedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule